// File: doc/BRIEF.md
# Synchronous serial port controller

This block is a master-mode synchronous serial port. A host writes 16-bit words through a small register interface into a transmit FIFO. The port shifts each word out on `txd_o`, most significant bit first. It generates the serial clock `sclk_o` and holds the frame strobe `sfrm_o` high for the whole frame. While one word goes out, the port assembles the incoming word from `rxd_i` and pushes it into a receive FIFO at the end of the frame. The host drains the receive FIFO by reading the data address.

A 6-bit control register sets the following:
- two interrupt enables that gate the FIFO-level flags onto `rx_irq_o` and `tx_irq_o`;
- an internal loopback path;
- the idle level of the serial clock;
- a phase bit that moves the idle time between the start and the end of the frame;
- the serial timing source, which is either a fixed divider of the system clock or an external clock input. The external input passes through a two-flop synchronizer, and each of its edges counts as one half serial period.

Both FIFOs are 12-entry shift-down queues. Entry 0 is always the oldest word, and a pop moves every entry down one place.

Top module: `ssp_master`

## Requirements
- R1: A write with `addr_i`=0 pushes `wdata_i` into the 12-entry transmit FIFO. A write while that FIFO holds 12 words is dropped.
- R2: A read with `addr_i`=0 returns the oldest received word on `rdata_o`, and asserting `rd_en_i` removes it. Words come out in arrival order, and reading an empty FIFO returns 0.
- R3: `rx_irq_o` is high exactly when control bit 0 is set and the receive FIFO holds 4 or more words. With bit 0 clear it stays low.
- R4: `tx_irq_o` is high exactly when control bit 1 is set and the transmit FIFO holds 6 or fewer words. With bit 1 clear it stays low.
- R5: With control bit 2 set, the transmitted bit stream is received in place of `rxd_i`, which is ignored. `sfrm_o` and `txd_o` stay low, and `sclk_o` stays at its idle level.
- R6: `sclk_o` sits at the level of control bit 3 whenever no frame is active (0 means idle low, 1 means idle high).
- R7: The time from the rise of `sfrm_o` to the first `sclk_o` edge, and from the last `sclk_o` edge to the fall of `sfrm_o`, depends on control bit 4. With bit 4 = 0 these are one full and one half serial period. With bit 4 = 1 they are one half and one full period. With the internal source, one half period is `DIV_HALF` clocks.
- R8: A frame carries 16 bits, MSB first. `txd_o` changes only on the edge that returns `sclk_o` to idle, and `rxd_i` is sampled on the edge that leaves idle. `sfrm_o` stays high from frame start to frame end.
- R9: A frame starts only when the transmit FIFO holds a word and the receive FIFO has a free entry. A word waiting behind a full receive FIFO is sent once an entry is read.
- R10: With control bit 5 set, serial timing advances only on edges of the synchronized `ext_clk_i`. While that input is static, no frame progresses.
- R11: The control register is at `addr_i`=1. Bit 0 enables the receive interrupt, bit 1 the transmit interrupt, bit 2 is loopback, bit 3 is clock polarity, bit 4 is clock phase and bit 5 selects the external clock. Bits 15..6 read as 0 and ignore writes, and the register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Data read strobe, pops the receive FIFO when `addr_i`=0 |
| addr_i | input | 1 | 0 selects data, 1 selects control |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected address |
| rxd_i | input | 1 | Serial receive data |
| ext_clk_i | input | 1 | External serial timing source |
| sclk_o | output | 1 | Serial clock |
| sfrm_o | output | 1 | Frame strobe |
| txd_o | output | 1 | Serial transmit data |
| rx_irq_o | output | 1 | Receive FIFO service request |
| tx_irq_o | output | 1 | Transmit FIFO service request |

## Verification
The hardest state to reach is a full receive FIFO with a word still waiting to transmit. Any receive traffic drains the transmit FIFO at the same time. The stimulus first freezes serial timing by selecting the static external clock and fills the transmit FIFO past its threshold and its capacity. It then switches to loopback on the internal clock, so twelve frames fill the receive FIFO while no pin activity occurs. A thirteenth word written afterwards must wait until the host reads, and the bench shows this by reading that word back last.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_DATA, ST_TAIL} frm_state_e;

  typedef struct packed {
    logic ext_clk;
    logic phase;
    logic polarity;
    logic loopback;
    logic tx_ie;
    logic rx_ie;
  } ssp_cfg_t;

  localparam int unsigned CFG_W = $bits(ssp_cfg_t);
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [WIDTH-1:0]               data_i,
  input  logic                           pop_i,
  output logic [WIDTH-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] down_nxt [DEPTH];
  logic [CNT_W-1:0] cnt_q, wr_idx;
  logic full, empty, do_push, do_pop;

  assign full    = cnt_q == CNT_W'(DEPTH);
  assign empty   = cnt_q == '0;
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign wr_idx  = do_pop ? cnt_q - 1'b1 : cnt_q;

  // shift-down path: each entry takes its upper neighbour on a pop
  for (genvar g = 0; g < DEPTH; g++) begin : g_down
    if (g == DEPTH-1) begin : g_top
      assign down_nxt[g] = '0;
    end else begin : g_mid
      assign down_nxt[g] = mem_q[g+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_push && wr_idx == CNT_W'(i)) mem_q[i] <= data_i;
        else if (do_pop)                    mem_q[i] <= down_nxt[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o = empty ? '0 : mem_q[0];
  assign cnt_o  = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> cnt_q == CNT_W'(DEPTH)); // R1
  AST_POP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && !do_push && cnt_q > 2) |=> mem_q[0] == $past(mem_q[1])); // R2
endmodule

// File: rtl/ssp_tick.sv
module ssp_tick #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_sel_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  localparam int unsigned DIV_W = $clog2(DIV_HALF+1);

  logic [DIV_W-1:0] div_q;
  logic [2:0]       sync_q;
  logic             int_tick;

  assign int_tick = div_q == DIV_W'(DIV_HALF-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sync_q <= '0;
    end else begin
      div_q  <= int_tick ? '0 : div_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_clk_i};
    end
  end

  // each synchronized edge of the external clock is one half period
  assign tick_o = ext_sel_i ? (sync_q[2] ^ sync_q[1]) : int_tick;
endmodule

// File: rtl/ssp_frame.sv
module ssp_frame
  import ssp_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             phase_i,
  input  logic             polarity_i,
  input  logic             loopback_i,
  input  logic             start_ok_i,
  input  logic [WIDTH-1:0] tx_word_i,
  input  logic             rxd_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [WIDTH-1:0] rx_word_o,
  output logic             sclk_o,
  output logic             sfrm_o,
  output logic             txd_o
);
  localparam int unsigned HALF_W    = $clog2(2*WIDTH);
  localparam int unsigned LAST_HALF = 2*WIDTH - 1;

  frm_state_e       state_q;
  logic [HALF_W-1:0] half_q;
  logic             tail_q;
  logic [WIDTH-1:0] tx_sh_q, rx_sh_q;
  logic             rx_bit;

  assign rx_bit    = loopback_i ? tx_sh_q[WIDTH-1] : rxd_i;
  assign tx_pop_o  = tick_i && state_q == ST_IDLE && start_ok_i;
  assign rx_push_o = tick_i && state_q == ST_TAIL && !tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      tail_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (start_ok_i) begin
          tx_sh_q <= tx_word_i;
          half_q  <= '0;
          state_q <= phase_i ? ST_DATA : ST_LEAD;
        end
        ST_LEAD: state_q <= ST_DATA;
        ST_DATA: begin
          if (!half_q[0]) begin
            // leading edge: sample
            rx_sh_q <= {rx_sh_q[WIDTH-2:0], rx_bit};
            half_q  <= half_q + 1'b1;
          end else begin
            // trailing edge: next bit
            tx_sh_q <= {tx_sh_q[WIDTH-2:0], 1'b0};
            if (half_q == HALF_W'(LAST_HALF)) begin
              state_q <= ST_TAIL;
              tail_q  <= phase_i;
            end else begin
              half_q <= half_q + 1'b1;
            end
          end
        end
        ST_TAIL: if (tail_q) tail_q <= 1'b0;
                 else        state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sfrm_o    = state_q != ST_IDLE;
  assign sclk_o    = polarity_i ^ (state_q == ST_DATA && half_q[0]);
  assign txd_o     = (state_q == ST_DATA) ? tx_sh_q[WIDTH-1] : 1'b0;
  assign rx_word_o = rx_sh_q;

  AST_IDLE_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sfrm_o |-> sclk_o == polarity_i); // R6
  AST_TXD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !half_q[0]) |=> $stable(tx_sh_q[WIDTH-1])); // R8
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 12,
  parameter int unsigned DIV_HALF   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rxd_i,
  input  logic              ext_clk_i,
  output logic              sclk_o,
  output logic              sfrm_o,
  output logic              txd_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH+1);
  localparam int unsigned RX_THR = FIFO_DEPTH / 3;
  localparam int unsigned TX_THR = FIFO_DEPTH / 2;

  ssp_cfg_t          cfg_q;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic              tx_pop, rx_push, tick, start_ok;
  logic              frm_sclk, frm_sfrm, frm_txd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_q <= '0;
    else if (wr_en_i && addr_i) cfg_q <= ssp_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (wr_en_i && !addr_i),
    .data_i (wdata_i),
    .pop_i  (tx_pop),
    .data_o (tx_head),
    .cnt_o  (tx_cnt)
  );

  ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .data_i (rx_word),
    .pop_i  (rd_en_i && !addr_i),
    .data_o (rx_head),
    .cnt_o  (rx_cnt)
  );

  ssp_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk_i, .rst_ni,
    .ext_sel_i (cfg_q.ext_clk),
    .ext_clk_i,
    .tick_o    (tick)
  );

  assign start_ok = tx_cnt != '0 && rx_cnt != CNT_W'(FIFO_DEPTH);

  ssp_frame #(.WIDTH(DATA_W)) u_frame (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .phase_i    (cfg_q.phase),
    .polarity_i (cfg_q.polarity),
    .loopback_i (cfg_q.loopback),
    .start_ok_i (start_ok),
    .tx_word_i  (tx_head),
    .rxd_i,
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_word_o  (rx_word),
    .sclk_o     (frm_sclk),
    .sfrm_o     (frm_sfrm),
    .txd_o      (frm_txd)
  );

  // loopback releases the pins to their quiet levels
  assign sclk_o = cfg_q.loopback ? cfg_q.polarity : frm_sclk;
  assign sfrm_o = !cfg_q.loopback && frm_sfrm;
  assign txd_o  = !cfg_q.loopback && frm_txd;

  assign rdata_o  = addr_i ? {{(DATA_W-CFG_W){1'b0}}, cfg_q} : rx_head;
  assign rx_irq_o = cfg_q.rx_ie && (rx_cnt >= CNT_W'(RX_THR));
  assign tx_irq_o = cfg_q.tx_ie && (tx_cnt <= CNT_W'(TX_THR));

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frm_sfrm) |-> $past(tx_cnt != '0 && rx_cnt != CNT_W'(FIFO_DEPTH))); // R9
endmodule

// File: tb/ssp_master_bench.sv
module ssp_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, addr = 0, rxd = 1'b1, ext_clk = 0;
  logic [15:0] wdata = '0, rdata;
  logic sclk_o, sfrm_o, txd_o, rx_irq, tx_irq;

  int vectors = 0, fails = 0, cyc = 0, frames = 0;
  logic pol = 0, pha = 0, lbm_mode = 0, timing_chk = 0, ext_run = 0, lb_leak = 0;
  logic [15:0] tx_exp[$], rx_exp[$];

  ssp_master #(.DATA_W(16), .FIFO_DEPTH(12), .DIV_HALF(DIV)) u_ssp_master (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .ext_clk_i(ext_clk),
    .sclk_o(sclk_o), .sfrm_o(sfrm_o), .txd_o(txd_o), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always begin
    #(CLK_PERIOD*3);
    if (ext_run) ext_clk = ~ext_clk;
  end

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int lead_cycles(input logic ph);
    return (ph ? 1 : 2) * DIV;
  endfunction
  function automatic int tail_cycles(input logic ph);
    return (ph ? 2 : 1) * DIV;
  endfunction

  // pin monitor and slave model
  logic prev_sclk = 0, prev_sfrm = 0;
  logic [15:0] mon_word = '0, slv_sh = '0, slv = '0, expw;
  int bitcnt = 0, t_rise = 0, t_first = 0, t_last = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lbm_mode && (sfrm_o || txd_o)) lb_leak = 1;
      if (sfrm_o && !prev_sfrm) begin
        frames++;
        t_rise = cyc; bitcnt = 0; mon_word = '0;
        slv = 16'($urandom);
        rx_exp.push_back(slv);
        rxd = slv[15];
        slv_sh = slv << 1;
      end
      if (sfrm_o && prev_sclk == pol && sclk_o != pol) begin
        if (bitcnt == 0) t_first = cyc;
        mon_word = {mon_word[14:0], txd_o};
        bitcnt++;
      end
      if (sfrm_o && prev_sclk != pol && sclk_o == pol) begin
        t_last = cyc;
        rxd = slv_sh[15];
        slv_sh = slv_sh << 1;
      end
      if (!sfrm_o && prev_sfrm) begin
        expw = (tx_exp.size() > 0) ? tx_exp.pop_front() : 16'hxxxx;
        chk(bitcnt == 16 && mon_word == expw, "R8 frame bits", mon_word, expw);
        if (timing_chk) begin
          chk(t_first - t_rise == lead_cycles(pha), "R7 lead idle", 16'(t_first - t_rise), 16'(lead_cycles(pha)));
          chk(cyc - t_last == tail_cycles(pha), "R7 tail idle", 16'(cyc - t_last), 16'(tail_cycles(pha)));
        end
        chk(sclk_o == pol, "R6 idle level", {15'b0, sclk_o}, {15'b0, pol});
      end
      prev_sclk = sclk_o;
      prev_sfrm = sfrm_o;
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    finish_run();
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask
  task automatic wr_ctrl(input logic [15:0] d);
    pol = d[3]; pha = d[4]; lbm_mode = d[2];
    wr(1'b1, d);
  endtask
  task automatic rd_data(output logic [15:0] v);
    @(negedge clk);
    addr = 0; rd_en = 1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v, w, w13;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    addr = 1; #1;
    chk(rdata == 16'h0, "R11 reset ctrl", rdata, 16'h0);
    chk(!sfrm_o && !sclk_o && !txd_o, "R6 reset pins", {13'b0, sfrm_o, sclk_o, txd_o}, 16'h0);
    chk(!tx_irq && !rx_irq, "R4 enable clear ignores empty tx", {14'b0, tx_irq, rx_irq}, 16'h0);
    addr = 0; #1;
    chk(rdata == 16'h0, "R2 empty read", rdata, 16'h0);

    wr_ctrl(16'hFFFF);
    @(negedge clk); addr = 1; #1;
    chk(rdata == 16'h003F, "R11 reserved bits", rdata, 16'h003F);

    // external clock static: FIFO fill without transmission
    wr_ctrl(16'h0022);
    @(negedge clk);
    chk(tx_irq == 1, "R4 empty tx", {15'b0, tx_irq}, 16'h1);
    chk(rx_irq == 0, "R3 disabled", {15'b0, rx_irq}, 16'h0);
    for (int i = 0; i < 13; i++) begin
      w = 16'($urandom);
      wr(1'b0, w);
      if (i < 12) rx_exp.push_back(w);
      if (i == 5) chk(tx_irq == 1, "R4 six words", {15'b0, tx_irq}, 16'h1);
      if (i == 6) chk(tx_irq == 0, "R4 seven words", {15'b0, tx_irq}, 16'h0);
    end
    wait_cyc(200);
    chk(frames == 0, "R10 static ext clock", 16'(frames), 16'h0);

    // loopback on internal clock drains into the rx FIFO
    rxd = 1'b1;
    wr_ctrl(16'h0005);
    wait_cyc(12*80 + 100);
    chk(rx_irq == 1, "R3 full rx", {15'b0, rx_irq}, 16'h1);
    chk(!lb_leak, "R5 pins quiet", {15'b0, lb_leak}, 16'h0);
    for (int i = 0; i < 12; i++) begin
      rd_data(v);
      w = rx_exp.pop_front();
      chk(v == w, "R5 loopback data R2 order", v, w);
      if (i == 7) chk(rx_irq == 1, "R3 four left", {15'b0, rx_irq}, 16'h1);
      if (i == 8) chk(rx_irq == 0, "R3 three left", {15'b0, rx_irq}, 16'h0);
    end
    rd_data(v);
    chk(v == 16'h0, "R1 write into full FIFO dropped", v, 16'h0);

    // rx full holds back the next frame
    for (int i = 0; i < 12; i++) begin
      w = 16'($urandom);
      wr(1'b0, w);
      rx_exp.push_back(w);
    end
    wait_cyc(12*80 + 100);
    w13 = 16'($urandom);
    wr(1'b0, w13);
    wait_cyc(300);
    for (int i = 0; i < 12; i++) begin
      rd_data(v);
      w = rx_exp.pop_front();
      chk(v == w, "R9 rx full stall order", v, w);
    end
    wait_cyc(150);
    rd_data(v);
    chk(v == w13, "R9 held word sent after read", v, w13);
    chk(!lb_leak, "R5 pins quiet", {15'b0, lb_leak}, 16'h0);

    // normal mode, all polarity/phase combinations, random words
    for (int m = 0; m < 4; m++) begin
      wr_ctrl({11'b0, m[1], m[0], 3'b000});
      timing_chk = 1;
      wait_cyc(4);
      chk(sclk_o == pol, "R6 idle level", {15'b0, sclk_o}, {15'b0, pol});
      for (int b = 0; b < 3; b++) begin
        int n;
        n = 1 + int'($urandom % 12);
        if (m == 0 && b == 0) n = 12;
        for (int i = 0; i < n; i++) begin
          w = 16'($urandom);
          if (m == 1 && i == 0) w = 16'h8001;
          tx_exp.push_back(w);
          wr(1'b0, w);
        end
        wait_cyc(n*80 + 100);
        for (int i = 0; i < n; i++) begin
          rd_data(v);
          w = (rx_exp.size() > 0) ? rx_exp.pop_front() : 16'hxxxx;
          chk(v == w, "R8 received word", v, w);
        end
      end
    end

    // external clock drives timing
    timing_chk = 0;
    wr_ctrl(16'h0020);
    ext_run = 1;
    for (int i = 0; i < 3; i++) begin
      w = 16'($urandom);
      tx_exp.push_back(w);
      wr(1'b0, w);
    end
    wait_cyc(3*220 + 200);
    for (int i = 0; i < 3; i++) begin
      rd_data(v);
      w = (rx_exp.size() > 0) ? rx_exp.pop_front() : 16'hxxxx;
      chk(v == w, "R10 external timing data", v, w);
    end
    chk(tx_exp.size() == 0, "R8 all frames seen", 16'(tx_exp.size()), 16'h0);
    finish_run();
  end
endmodule